// File: doc/BRIEF.md
# Clock Output Power-Down Controller

This block sequences the clock outputs of a multi-output clock generator into and out of a low-power state. A single input pin has two jobs. Right after power-on it is a power-good qualifier: the oscillator and PLL stay disabled until the pin is first seen high. From then on the same pin is an active-low power-down request. The pin is asynchronous, so it is resynchronized into the reference clock domain. A request takes effect only when two consecutive synchronized samples show it low.

On a recognized request, every output is stopped inside its own clock domain. A single-ended output, and the true leg of a differential pair, stops at its next falling edge. The complement leg stops at its own falling edge. Every output then stays low. The oscillator and PLL enables drop only once every output has reported that it is held low. Two configuration bits select what power-down does to the configuration. Without the management bit, the restore-select bit chooses between keeping the configuration and a full cold-start reset. A cold-start reset puts the pin back into its power-good role.

On release, the oscillator and PLL are enabled again. Once the PLL reports lock, each output restarts with a full first pulse. A lock wait that runs longer than a set number of reference cycles raises an error flag.

Top module: `clk_pd_top`

## Requirements
- R1: After the reset input is released, oscEn, pllEn, cfgReset, lockErr and every clock output are low.
- R2: The first time pwrPin goes high, oscEn and pllEn rise together after the third refClk rising edge that follows the change, and not after the second.
- R3: While the PLL lock is awaited, every output stays low. After pllLock rises, every output toggles again within three refClk cycles plus four of its own periods. This covers each single-ended output and both legs of each differential pair.
- R4: A power-down request (pwrPin low) that lasts only one refClk cycle, and so gives a single synchronized low sample, is ignored: oscEn stays high and every output keeps toggling.
- R5: A request held low for two or more refClk cycles stops every output, holding it low, and drops oscEn and pllEn within 200 refClk cycles.
- R6: oscEn is never low while any clock output is high.
- R7: No output produces a runt. Every high phase lasts exactly half its clock period, and every low phase lasts at least half its period, across entry and exit.
- R8: Completing power-down yields a single-cycle cfgReset pulse exactly when cfgRestore (configuration byte 0, bit 0) is 0 and cfgMgmt (byte 0, bit 3) is 0. The other three combinations yield no pulse.
- R9: When the pin goes high again after power-down, oscEn and pllEn rise after the third refClk rising edge, in every mode combination.
- R10: If pllLock is still low LOCK_TIMEOUT refClk edges after oscEn rose, lockErr is set on that edge and not one edge before. lockErr stays set until the next wake-up begins, and is low in the cycle in which oscEn rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference (CPU-domain) clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| pwrPin | input | 1 | Power-good first, then active-low power-down request |
| cfgRestore | input | 1 | Configuration byte 0 bit 0: 1 keeps configuration, 0 cold-starts |
| cfgMgmt | input | 1 | Configuration byte 0 bit 3: 1 forbids any reset on power-down |
| pllLock | input | 1 | PLL lock indication |
| seClkIn | input | NUM_SE | Ungated single-ended clocks from the synthesizer |
| diffClkIn | input | NUM_DIFF | Ungated differential clocks (true phase) |
| seClkOut | output | NUM_SE | Gated single-ended clocks |
| diffClkOutT | output | NUM_DIFF | Gated differential true legs |
| diffClkOutC | output | NUM_DIFF | Gated differential complement legs |
| oscEn | output | 1 | Crystal oscillator enable |
| pllEn | output | 1 | PLL/VCO enable |
| cfgReset | output | 1 | One-cycle cold-start reset request for the configuration registers |
| lockErr | output | 1 | PLL lock wait timed out |

## Verification
The checks assume that every output clock keeps toggling whenever the oscillator is enabled, since the stop and restart handshakes rely on those edges. The stimulus runs all five output clocks freely at unrelated periods. The checks also assume that the two configuration bits are held steady across a power-down. The stimulus changes them only while the block is running, before it lowers the pin. pwrPin and pllLock are driven away from the refClk rising edge, which gives the synchronizer delays the exact three-edge count that the timing properties rely on.

// File: rtl/clk_pd_pkg.sv
package clk_pd_pkg;

  typedef enum logic [2:0] {
    ST_PGOOD_WAIT,
    ST_WAKE_LOCK,
    ST_RUN,
    ST_PD_ENTRY,
    ST_PD_OFF
  } pdState_e;

  // strobes from the control to the output datapath
  typedef struct packed {
    logic gateEn;
    logic oscEn;
    logic pllEn;
    logic cfgReset;
  } pdStrobe_t;

  // lane status returned by the datapath, already in the refClk domain
  typedef struct packed {
    logic allOn;
    logic allOff;
  } pdStatus_t;

endpackage

// File: rtl/clk_pd_sync.sv
module clk_pd_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/clk_pd_ctrl.sv
module clk_pd_ctrl
  import clk_pd_pkg::*;
#(
  parameter int LOCK_TIMEOUT = 239400,
  parameter int SYNC_STAGES  = 2
) (
  input  logic      refClk,
  input  logic      rstN,
  input  logic      pwrPin,
  input  logic      cfgRestore,
  input  logic      cfgMgmt,
  input  logic      pllLock,
  input  pdStatus_t status,
  output pdStrobe_t strobe,
  output logic      lockErr
);
  localparam int CNT_W = $clog2(LOCK_TIMEOUT + 1);
  localparam logic [CNT_W-1:0] LIMIT    = CNT_W'(LOCK_TIMEOUT);
  localparam logic [CNT_W-1:0] LIMIT_M1 = CNT_W'(LOCK_TIMEOUT - 1);

  logic [1:0]       syncQ;
  logic             pinS, lockS;
  logic             prevLow;
  logic             doReset;
  logic [CNT_W-1:0] waitCnt;
  pdState_e         state, nxt;

  clk_pd_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_inSync (
    .clk(refClk), .rstN(rstN), .d({pllLock, pwrPin}), .q(syncQ)
  );
  assign pinS  = syncQ[0];
  assign lockS = syncQ[1];

  always_comb begin
    nxt = state;
    unique case (state)
      ST_PGOOD_WAIT: if (pinS) nxt = ST_WAKE_LOCK;
      ST_WAKE_LOCK:  if (lockS) nxt = ST_RUN;
      ST_RUN:        if (!pinS && prevLow && status.allOn) nxt = ST_PD_ENTRY;
      ST_PD_ENTRY:   if (status.allOff) nxt = doReset ? ST_PGOOD_WAIT : ST_PD_OFF;
      ST_PD_OFF:     if (pinS) nxt = ST_WAKE_LOCK;
      default:       nxt = ST_PGOOD_WAIT;
    endcase
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_PGOOD_WAIT;
      prevLow <= 1'b0;
      doReset <= 1'b0;
      waitCnt <= '0;
      lockErr <= 1'b0;
      strobe  <= '0;
    end else begin
      state           <= nxt;
      prevLow         <= !pinS;
      strobe.gateEn   <= (nxt == ST_RUN);
      strobe.oscEn    <= (nxt == ST_WAKE_LOCK) || (nxt == ST_RUN) || (nxt == ST_PD_ENTRY);
      strobe.pllEn    <= (nxt == ST_WAKE_LOCK) || (nxt == ST_RUN) || (nxt == ST_PD_ENTRY);
      strobe.cfgReset <= (state == ST_PD_ENTRY) && status.allOff && doReset;
      if (state == ST_RUN && nxt == ST_PD_ENTRY)
        doReset <= !cfgRestore && !cfgMgmt;
      if (nxt == ST_WAKE_LOCK && state != ST_WAKE_LOCK) begin
        waitCnt <= '0;
        lockErr <= 1'b0;
      end else if (state == ST_WAKE_LOCK) begin
        if (waitCnt < LIMIT) waitCnt <= waitCnt + 1'b1;
        if (waitCnt == LIMIT_M1 && !lockS) lockErr <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/clk_pd_gate.sv
module clk_pd_gate
  import clk_pd_pkg::*;
#(
  parameter int NUM_SE      = 3,
  parameter int NUM_DIFF    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       refClk,
  input  logic                       rstN,
  input  pdStrobe_t                  strobe,
  input  logic [NUM_SE+NUM_DIFF-1:0] clkIn,
  output logic [NUM_SE+NUM_DIFF-1:0] outT,
  output logic [NUM_DIFF-1:0]        outC,
  output pdStatus_t                  status,
  output logic                       oscEn,
  output logic                       pllEn,
  output logic                       cfgReset
);
  localparam int NUM_OUT = NUM_SE + NUM_DIFF;

  logic [NUM_OUT-1:0]  enSync, enT, laneOn, laneAny;
  logic [NUM_DIFF-1:0] enC;
  logic [NUM_OUT-1:0]  onS, anyS;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_lane
    clk_pd_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_enSync (
      .clk(clkIn[i]), .rstN(rstN), .d(strobe.gateEn), .q(enSync[i])
    );
    // enable changes only while the clock is low
    always_ff @(negedge clkIn[i] or negedge rstN) begin
      if (!rstN) enT[i] <= 1'b0;
      else       enT[i] <= enSync[i];
    end
    assign outT[i] = clkIn[i] & enT[i];

    if (i >= NUM_SE) begin : g_diff
      // complement leg is low while the true phase is high
      always_ff @(posedge clkIn[i] or negedge rstN) begin
        if (!rstN) enC[i-NUM_SE] <= 1'b0;
        else       enC[i-NUM_SE] <= enSync[i];
      end
      assign outC[i-NUM_SE] = ~clkIn[i] & enC[i-NUM_SE];
      assign laneOn[i]  = enT[i] & enC[i-NUM_SE];
      assign laneAny[i] = enT[i] | enC[i-NUM_SE];
    end else begin : g_single
      assign laneOn[i]  = enT[i];
      assign laneAny[i] = enT[i];
    end
  end

  clk_pd_sync #(.WIDTH(2*NUM_OUT), .STAGES(SYNC_STAGES)) u_ackSync (
    .clk(refClk), .rstN(rstN), .d({laneAny, laneOn}), .q({anyS, onS})
  );

  assign status.allOn  = &onS;
  assign status.allOff = ~|anyS;
  assign oscEn    = strobe.oscEn;
  assign pllEn    = strobe.pllEn;
  assign cfgReset = strobe.cfgReset;
endmodule

// File: rtl/clk_pd_top.sv
module clk_pd_top
  import clk_pd_pkg::*;
#(
  parameter int NUM_SE       = 3,
  parameter int NUM_DIFF     = 2,
  parameter int SYNC_STAGES  = 2,
  parameter int REF_KHZ      = 133000,
  parameter int LOCK_TIMEOUT = REF_KHZ * 18 / 10
) (
  input  logic                refClk,
  input  logic                rstN,
  input  logic                pwrPin,
  input  logic                cfgRestore,
  input  logic                cfgMgmt,
  input  logic                pllLock,
  input  logic [NUM_SE-1:0]   seClkIn,
  input  logic [NUM_DIFF-1:0] diffClkIn,
  output logic [NUM_SE-1:0]   seClkOut,
  output logic [NUM_DIFF-1:0] diffClkOutT,
  output logic [NUM_DIFF-1:0] diffClkOutC,
  output logic                oscEn,
  output logic                pllEn,
  output logic                cfgReset,
  output logic                lockErr
);
  pdStrobe_t strobe;
  pdStatus_t status;
  logic [NUM_SE+NUM_DIFF-1:0] gatedT;

  clk_pd_ctrl #(.LOCK_TIMEOUT(LOCK_TIMEOUT), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .refClk(refClk), .rstN(rstN), .pwrPin(pwrPin), .cfgRestore(cfgRestore),
    .cfgMgmt(cfgMgmt), .pllLock(pllLock), .status(status), .strobe(strobe),
    .lockErr(lockErr)
  );

  clk_pd_gate #(.NUM_SE(NUM_SE), .NUM_DIFF(NUM_DIFF), .SYNC_STAGES(SYNC_STAGES)) u_gate (
    .refClk(refClk), .rstN(rstN), .strobe(strobe), .clkIn({diffClkIn, seClkIn}),
    .outT(gatedT), .outC(diffClkOutC), .status(status), .oscEn(oscEn),
    .pllEn(pllEn), .cfgReset(cfgReset)
  );

  assign seClkOut    = gatedT[NUM_SE-1:0];
  assign diffClkOutT = gatedT[NUM_SE+NUM_DIFF-1:NUM_SE];
endmodule

// File: rtl/clk_pd_chk.sv
module clk_pd_chk #(
  parameter int NUM_SE   = 3,
  parameter int NUM_DIFF = 2
) (
  input logic                refClk,
  input logic                rstN,
  input logic                pwrPin,
  input logic                cfgRestore,
  input logic                cfgMgmt,
  input logic [NUM_SE-1:0]   seClkOut,
  input logic [NUM_DIFF-1:0] diffClkOutT,
  input logic [NUM_DIFF-1:0] diffClkOutC,
  input logic                oscEn,
  input logic                pllEn,
  input logic                cfgReset,
  input logic                lockErr
);
  AST_OFF_OUTPUTS_LOW: assert property (@(posedge refClk) disable iff (!rstN)
    !oscEn |-> (seClkOut == '0) && (diffClkOutT == '0) && (diffClkOutC == '0)); // R6
  AST_OSC_AFTER_PIN: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(oscEn) |-> $past(pwrPin, 2)); // R2
  AST_RESET_PULSE_SHORT: assert property (@(posedge refClk) disable iff (!rstN)
    cfgReset |=> !cfgReset); // R8
  AST_RESET_MODE: assert property (@(posedge refClk) disable iff (!rstN)
    cfgReset |-> !cfgRestore && !cfgMgmt && !oscEn); // R8
  AST_ERR_WHILE_WAITING: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(lockErr) |-> oscEn && pllEn); // R10
  AST_ERR_CLEAR_ON_WAKE: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(oscEn) |-> !lockErr); // R10
endmodule

bind clk_pd_top clk_pd_chk #(.NUM_SE(NUM_SE), .NUM_DIFF(NUM_DIFF)) u_chk (
  .refClk(refClk), .rstN(rstN), .pwrPin(pwrPin), .cfgRestore(cfgRestore),
  .cfgMgmt(cfgMgmt), .seClkOut(seClkOut), .diffClkOutT(diffClkOutT),
  .diffClkOutC(diffClkOutC), .oscEn(oscEn), .pllEn(pllEn), .cfgReset(cfgReset),
  .lockErr(lockErr)
);

// File: tb/sim_clk_pd_top.sv
`timescale 1ns/1ps
module sim_clk_pd_top;
  localparam int LIMIT = 40;
  localparam int SE_HALF [3] = '{15, 7, 22};
  localparam int DF_HALF [2] = '{8, 13};
  localparam int MON_HALF [7] = '{15, 7, 22, 8, 13, 8, 13};

  logic refClk = 0, rstN = 0, pwrPin = 0, cfgRestore = 0, cfgMgmt = 0, pllLock = 0;
  logic [2:0] seIn = '0;
  logic [1:0] dfIn = '0;
  logic [2:0] seOut;
  logic [1:0] dfT, dfC;
  logic oscEn, pllEn, cfgReset, lockErr;
  logic [6:0] mon;

  int checks = 0, errors = 0;
  int riseCount [7];

  always #10 refClk = ~refClk;
  for (genvar g = 0; g < 3; g++) begin : g_seClk
    always #(SE_HALF[g]) seIn[g] = ~seIn[g];
  end
  for (genvar g = 0; g < 2; g++) begin : g_dfClk
    always #(DF_HALF[g]) dfIn[g] = ~dfIn[g];
  end

  clk_pd_top #(.NUM_SE(3), .NUM_DIFF(2), .LOCK_TIMEOUT(LIMIT)) u0 (
    .refClk(refClk), .rstN(rstN), .pwrPin(pwrPin), .cfgRestore(cfgRestore),
    .cfgMgmt(cfgMgmt), .pllLock(pllLock), .seClkIn(seIn), .diffClkIn(dfIn),
    .seClkOut(seOut), .diffClkOutT(dfT), .diffClkOutC(dfC), .oscEn(oscEn),
    .pllEn(pllEn), .cfgReset(cfgReset), .lockErr(lockErr)
  );

  assign mon = {dfC, dfT, seOut};

  function automatic void chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endfunction

  // pulse-width monitor on every output leg (R7)
  for (genvar i = 0; i < 7; i++) begin : g_mon
    realtime tRise = 0, tFall = 0;
    bit seenRise = 0, seenFall = 0;
    always @(posedge mon[i]) begin
      if (seenFall)
        chk(($realtime - tFall) > MON_HALF[i] - 0.01, "R7", $sformatf("low phase lane %0d", i),
            int'($realtime - tFall), MON_HALF[i]);
      tRise = $realtime; seenRise = 1; riseCount[i]++;
    end
    always @(negedge mon[i]) begin
      if (seenRise)
        chk(($realtime - tRise) > MON_HALF[i] - 0.01 && ($realtime - tRise) < MON_HALF[i] + 0.01,
            "R7", $sformatf("high phase lane %0d", i), int'($realtime - tRise), MON_HALF[i]);
      tFall = $realtime; seenFall = 1;
    end
  end

  // every refClk: outputs quiet whenever the oscillator is off (R6)
  always @(negedge refClk)
    if (rstN && !oscEn) chk(mon == '0, "R6", "outputs with oscEn low", int'(mon), 0);

  task automatic clearRises();
    for (int i = 0; i < 7; i++) riseCount[i] = 0;
  endtask

  task automatic expectAllToggle(string req);
    for (int i = 0; i < 7; i++)
      chk(riseCount[i] > 0, req, $sformatf("rises lane %0d", i), riseCount[i], 1);
  endtask

  task automatic wakeCheck(string req);
    @(negedge refClk); pwrPin = 1;
    @(posedge refClk); @(posedge refClk); @(negedge refClk);
    chk(oscEn == 0, req, "oscEn after 2 edges", oscEn, 0);
    @(posedge refClk); @(negedge refClk);
    chk(oscEn && pllEn, req, "osc/pll after 3 edges", {oscEn, pllEn}, 3);
  endtask

  task automatic lockCheck();
    repeat (5) @(negedge refClk);
    chk(mon == '0, "R3", "outputs while awaiting lock", int'(mon), 0);
    clearRises();
    pllLock = 1;
    repeat (3) @(negedge refClk);
    #(4 * 44 + 10);
    expectAllToggle("R3");
  endtask

  task automatic enterPd(int mode, int expPulses);
    int pulses = 0;
    bit off = 0;
    cfgRestore = mode[0]; cfgMgmt = mode[1];
    @(negedge refClk); pwrPin = 0;
    for (int c = 0; c < 200; c++) begin
      @(negedge refClk);
      if (cfgReset) pulses++;
      if (!oscEn) begin off = 1; break; end
    end
    chk(off && !pllEn, "R5", $sformatf("osc/pll off, mode %0d", mode), {oscEn, pllEn}, 0);
    chk(mon == '0, "R5", "outputs held low", int'(mon), 0);
    pllLock = 0;
    repeat (10) begin
      @(negedge refClk);
      if (cfgReset) pulses++;
    end
    chk(oscEn == 0, "R5", "oscEn stays low", oscEn, 0);
    chk(pulses == expPulses, "R8", $sformatf("cfgReset cycles, mode %0d", mode), pulses, expPulses);
  endtask

  initial begin
    #(100000 * 20);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge refClk);
    rstN = 1;
    @(negedge refClk);
    chk({oscEn, pllEn, cfgReset, lockErr} == 0, "R1", "controls after reset",
        {oscEn, pllEn, cfgReset, lockErr}, 0);
    chk(mon == '0, "R1", "outputs after reset", int'(mon), 0);

    wakeCheck("R2");
    lockCheck();

    // single synchronized low sample
    @(negedge refClk); pwrPin = 0;
    @(negedge refClk); pwrPin = 1;
    repeat (10) @(negedge refClk);
    chk(oscEn == 1, "R4", "oscEn after short low", oscEn, 1);
    clearRises();
    #(4 * 44 + 10);
    expectAllToggle("R4");

    // all four mode combinations: reset only when both bits are 0
    for (int m = 0; m < 4; m++) begin
      enterPd(m, (m == 0) ? 1 : 0);
      wakeCheck("R9");
      lockCheck();
    end

    // lock timeout
    enterPd(1, 0);
    @(negedge refClk); pwrPin = 1;
    repeat (3) @(posedge refClk);
    @(negedge refClk);
    chk(oscEn == 1, "R10", "oscEn on wake", oscEn, 1);
    repeat (LIMIT - 1) @(posedge refClk);
    @(negedge refClk);
    chk(lockErr == 0, "R10", "lockErr one edge early", lockErr, 0);
    @(posedge refClk); @(negedge refClk);
    chk(lockErr == 1, "R10", "lockErr at limit", lockErr, 1);
    lockCheck();
    chk(lockErr == 1, "R10", "lockErr held after lock", lockErr, 1);
    enterPd(3, 0);
    wakeCheck("R9");
    chk(lockErr == 0, "R10", "lockErr cleared on wake", lockErr, 0);
    lockCheck();

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule